// File: doc/BRIEF.md
# Reference-Window Frequency Meter

This block measures how fast an unknown clock runs by counting its rising edges during a window whose length is a programmed number of reference-clock cycles. Software writes the window length and an enable into a control word, sets a separate free-run clock enable in a status word, and then polls a sticky valid flag. Once the window has closed and the count has settled, the count is latched into a monitor register and the flag rises. The flag stays up until software drops either enable, which also returns the meter to idle.

The measured clock is asynchronous to the reference clock. The edge counter lives in the measured domain and is held cleared while the meter is idle. It starts when a synchronized start level reaches it, and its value returns to the reference domain as gray code through a two-flop synchronizer. A fixed settle interval after the window lets the last increment arrive before it is latched. If the measured clock is stopped, the latched count is zero, which software reads as a failed detection. The counter saturates at its maximum instead of wrapping. The register port is a simple single-cycle write and combinational read interface, clocked by the reference clock.

Top module: `refwin_freq_meter`

## Requirements
- R1: After reset the control word (address 0) reads 0x0000_0400, which is a window of 1024 with the enable clear. The status word (address 1) and the monitor word (address 2) read 0.
- R2: The control word holds the window length in bits 23:0 and the meter enable in bit 24, and its bits 31:25 read 0. In the status word, bit 8 is the read/write free-run clock enable and bit 0 is the read-only valid flag, and all other bits read 0. Writes to the monitor word (address 2) are ignored.
- R3: Let E be the clock edge after which the meter enable and the free-run enable are both set. The valid flag is first seen set after edge E+1+4+W+16, where W is the window field, and a field of 0 counts as a window of 1.
- R4: The monitor word reports the number of measured-clock rising edges seen in the window, within ±3 of W·f_meas/f_ref.
- R5: With the measured clock stopped, the measurement still completes and the monitor word reads exactly 0.
- R6: The valid flag stays set while both enables stay set. It is clear after the edge that follows clearing either enable. Setting both enables again starts a new measurement with the R3 timing.
- R7: While the free-run enable is clear, no measurement runs, the valid flag never sets and the monitor word does not change.
- R8: The edge count saturates at 2^CNT_W−1 and does not wrap. With CNT_W=8, a window holding more than 255 edges reads 255.
- R9: The monitor word changes only when a new result is latched. It keeps its last result after the meter is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; it also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_clk | input | 1 | Clock whose frequency is measured |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 monitor |
| reg_wr | input | 1 | Write strobe, sampled on ref_clk |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |

## Verification
A window timer that is off by one shows up in the valid flag, one reference cycle early or late, at the very edge where the flag should rise. The bench compares that flag with its own model on every cycle. A fault in the counter or in the gray crossing appears only later, in the monitor word after valid: it reads as a count outside the ±3 band, as a stale value, or as a wrapped value where saturation was due. A meter that fails to return to idle is exposed on the next enable, when valid either rises early or keeps the old result.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_RUN, ST_SETTLE, ST_DONE
  } fm_state_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_MON  = 2'd2;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/fm_meas_counter.sv
module fm_meas_counter #(
  parameter int CNT_W = 32
) (
  input  logic             meas_clk,
  input  logic             meas_rst_n,
  input  logic             go_ref,
  output logic [CNT_W-1:0] gray_o,
  output logic             cnt_sat
);
  import fm_pkg::*;

  logic             go_s1, go_s2;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign cnt_sat = &cnt_q;
  assign cnt_nxt = (go_s2 && !cnt_sat) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge meas_clk or negedge meas_rst_n) begin
    if (!meas_rst_n) begin
      go_s1  <= 1'b0;
      go_s2  <= 1'b0;
      cnt_q  <= '0;
      gray_o <= '0;
    end else begin
      go_s1  <= go_ref;
      go_s2  <= go_s1;
      cnt_q  <= cnt_nxt;
      gray_o <= CNT_W'(bin2gray(32'(cnt_nxt)));
    end
  end
endmodule

// File: rtl/fm_gray_sync.sv
module fm_gray_sync #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_i,
  output logic [CNT_W-1:0] bin_o
);
  import fm_pkg::*;

  logic [CNT_W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  assign bin_o = CNT_W'(gray2bin(32'(s2_q)));
endmodule

// File: rtl/fm_window_ctrl.sv
module fm_window_ctrl #(
  parameter int WIN_W      = 24,
  parameter int ARM_CYC    = 4,
  parameter int SETTLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_ok,
  input  logic [WIN_W-1:0] win_len,
  output logic             go,
  output logic             clr,
  output logic             latch_evt,
  output logic             in_settle
);
  import fm_pkg::*;

  localparam logic [WIN_W-1:0] ARM_LOAD    = WIN_W'(ARM_CYC - 1);
  localparam logic [WIN_W-1:0] SETTLE_LOAD = WIN_W'(SETTLE_CYC - 1);

  fm_state_t        state_q, state_d;
  logic [WIN_W-1:0] tmr_q, tmr_d;
  logic [WIN_W-1:0] win_eff;
  logic             tmr_zero;

  assign win_eff   = (win_len == '0) ? WIN_W'(1) : win_len;
  assign tmr_zero  = (tmr_q == '0);
  assign in_settle = (state_q == ST_SETTLE);
  assign latch_evt = in_settle && tmr_zero && run_ok;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_zero ? tmr_q : tmr_q - 1'b1;
    if (!run_ok) begin
      state_d = ST_IDLE;
      tmr_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_ARM;
          tmr_d   = ARM_LOAD;
        end
        ST_ARM: if (tmr_zero) begin
          state_d = ST_RUN;
          tmr_d   = win_eff - 1'b1;
        end
        ST_RUN: if (tmr_zero) begin
          state_d = ST_SETTLE;
          tmr_d   = SETTLE_LOAD;
        end
        ST_SETTLE: if (tmr_zero) state_d = ST_DONE;
        default: state_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      go      <= 1'b0;
      clr     <= 1'b1;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      go      <= (state_d == ST_RUN);
      clr     <= (state_d == ST_IDLE);
    end
  end
endmodule

// File: rtl/refwin_freq_meter.sv
module refwin_freq_meter #(
  parameter int CNT_W      = 32,
  parameter int WIN_W      = 24,
  parameter int WIN_RST    = 1024,
  parameter int ARM_CYC    = 4,
  parameter int SETTLE_CYC = 16
) (
  input  logic        ref_clk,
  input  logic        rst_n,
  input  logic        meas_clk,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  import fm_pkg::*;

  localparam int EN_BIT    = WIN_W;
  localparam int FRC_BIT   = 8;
  localparam int VALID_BIT = 0;

  logic [WIN_W-1:0] ctrl_win;
  logic             ctrl_en, frc_en, valid_q, run_ok;
  logic [CNT_W-1:0] mon_q, gray_w, cnt_ref;
  logic             go, clr, latch_evt, in_settle, cnt_sat, meas_rst_n;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[31:EN_BIT+1];
  assign run_ok          = ctrl_en && frc_en;
  assign meas_rst_n      = rst_n && !clr;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_win <= WIN_W'(WIN_RST);
      ctrl_en  <= 1'b0;
      frc_en   <= 1'b0;
      valid_q  <= 1'b0;
      mon_q    <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) begin
        ctrl_win <= reg_wdata[WIN_W-1:0];
        ctrl_en  <= reg_wdata[EN_BIT];
      end
      if (reg_wr && reg_addr == ADDR_STAT) frc_en <= reg_wdata[FRC_BIT];
      if (latch_evt) begin
        mon_q   <= cnt_ref;
        valid_q <= 1'b1;
      end else if (!run_ok) begin
        valid_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[WIN_W-1:0] = ctrl_win;
        reg_rdata[EN_BIT]    = ctrl_en;
      end
      ADDR_STAT: begin
        reg_rdata[FRC_BIT]   = frc_en;
        reg_rdata[VALID_BIT] = valid_q;
      end
      ADDR_MON: reg_rdata[CNT_W-1:0] = mon_q;
      default:  reg_rdata = '0;
    endcase
  end

  fm_window_ctrl #(.WIN_W(WIN_W), .ARM_CYC(ARM_CYC), .SETTLE_CYC(SETTLE_CYC)) u_win (
    .clk(ref_clk), .rst_n(rst_n), .run_ok(run_ok), .win_len(ctrl_win),
    .go(go), .clr(clr), .latch_evt(latch_evt), .in_settle(in_settle)
  );

  fm_meas_counter #(.CNT_W(CNT_W)) u_cnt (
    .meas_clk(meas_clk), .meas_rst_n(meas_rst_n), .go_ref(go),
    .gray_o(gray_w), .cnt_sat(cnt_sat)
  );

  fm_gray_sync #(.CNT_W(CNT_W)) u_sync (
    .clk(ref_clk), .rst_n(rst_n), .gray_i(gray_w), .bin_o(cnt_ref)
  );
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             meas_clk,
  input logic             meas_rst_n,
  input logic             run_ok,
  input logic             frc_en,
  input logic             go,
  input logic             valid,
  input logic             latch_evt,
  input logic             in_settle,
  input logic [CNT_W-1:0] mon,
  input logic             cnt_sat
);
  assert_valid_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> !valid);

  assert_idle_without_freerun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frc_en |=> (!go && !valid));

  assert_valid_after_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(in_settle));

  assert_monitor_only_on_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mon) |-> $past(latch_evt));

  assert_no_overflow_R8: assert property (@(posedge meas_clk) disable iff (!meas_rst_n)
    cnt_sat |=> cnt_sat);
endmodule

bind refwin_freq_meter fm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(ref_clk), .rst_n(rst_n), .meas_clk(meas_clk), .meas_rst_n(meas_rst_n),
  .run_ok(run_ok), .frc_en(frc_en), .go(go), .valid(valid_q),
  .latch_evt(latch_evt), .in_settle(in_settle), .mon(mon_q), .cnt_sat(cnt_sat)
);

// File: tb/tb_refwin_freq_meter.sv
`timescale 1ns/1ps
module tb_refwin_freq_meter;
  localparam int ARM = 4;
  localparam int SET = 16;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_MON = 2'd2;

  logic        ref_clk = 1'b0, meas_clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  reg_addr = A_STAT;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_sat;
  real         meas_half = 3.0;
  bit          meas_run = 1'b1;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  // reference model state
  bit m_en, m_frc, m_valid;
  int m_win, m_el;

  refwin_freq_meter dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .meas_clk(meas_clk), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata));

  refwin_freq_meter #(.CNT_W(8)) dut_sat (
    .ref_clk(ref_clk), .rst_n(rst_n), .meas_clk(meas_clk), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata_sat));

  always #2 ref_clk = ~ref_clk;
  always begin
    if (meas_run) #(meas_half) meas_clk = ~meas_clk;
    else #1;
  end

  function automatic int weff(int w);
    return (w == 0) ? 1 : w;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, one step per reference edge
  always @(posedge ref_clk) begin
    if (!rst_n) begin
      m_en = 0; m_frc = 0; m_win = 1024; m_el = -1; m_valid = 0;
    end else begin
      if (!(m_en && m_frc)) begin
        m_el = -1; m_valid = 0;
      end else begin
        m_el++;
        if (m_el == ARM + weff(m_win) + SET) m_valid = 1;
      end
      if (reg_wr && reg_addr == A_CTRL) begin
        m_win = int'(reg_wdata[23:0]); m_en = reg_wdata[24];
      end
      if (reg_wr && reg_addr == A_STAT) m_frc = reg_wdata[8];
    end
  end

  // every-cycle comparison of the valid flag (R3, R6, R7)
  always @(negedge ref_clk) begin
    #1;
    if (rst_n && !done && reg_addr == A_STAT) begin
      chk(rdata[0] == m_valid, "R3 R6 R7 valid flag", rdata[0], m_valid);
      chk(rdata_sat[0] == m_valid, "R3 valid flag (narrow)", rdata_sat[0], m_valid);
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge ref_clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge ref_clk);
    reg_wr = 1'b0; reg_addr = A_STAT;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v, output logic [31:0] vs);
    @(negedge ref_clk);
    reg_addr = a;
    #0.5;
    v = rdata; vs = rdata_sat;
    reg_addr = A_STAT;
  endtask

  task automatic measure(int w, real tm, bit run, output logic [31:0] got, output logic [31:0] got_s);
    logic [31:0] st, sts;
    meas_half = tm / 2.0; meas_run = run;
    repeat (4) @(negedge ref_clk);
    wr(A_CTRL, 32'h0100_0000 | 32'(w));
    repeat (ARM + weff(w) + SET + 4) @(negedge ref_clk);
    rd(A_STAT, st, sts);
    chk(st[0] == 1'b1, "R3 valid after window", st[0], 1);
    rd(A_MON, got, got_s);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, vs, keep;
    real exp;
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (2) @(negedge ref_clk);

    // R1 reset values
    rd(A_CTRL, v, vs); chk(v == 32'h0000_0400, "R1 control reset", v, 32'h400);
    rd(A_STAT, v, vs); chk(v == 32'h0, "R1 status reset", v, 0);
    rd(A_MON, v, vs);  chk(v == 32'h0, "R1 monitor reset", v, 0);

    // R2 field layout
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v, vs); chk(v == 32'h0000_0100, "R2 status fields", v, 32'h100);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v, vs); chk(v == 32'h0, "R2 status clear", v, 0);
    wr(A_CTRL, 32'hFE00_1234);
    rd(A_CTRL, v, vs); chk(v == 32'h0000_1234, "R2 control fields", v, 32'h1234);
    wr(A_MON, 32'h0000_DEAD);
    rd(A_MON, v, vs); chk(v == 32'h0, "R2 monitor write ignored", v, 0);

    // R7 no free-run enable: nothing happens
    wr(A_CTRL, 32'h0100_0032);
    repeat (150) @(negedge ref_clk);
    rd(A_STAT, v, vs); chk(v[0] == 1'b0, "R7 valid stays low", v[0], 0);
    rd(A_MON, v, vs);  chk(v == 32'h0, "R7 monitor unchanged", v, 0);
    wr(A_CTRL, 32'h0000_0032);

    wr(A_STAT, 32'h0000_0100);

    // R4 several ratios
    measure(1000, 6.0, 1, v, vs);
    exp = 1000.0 * 4.0 / 6.0;
    chk((real'(v) - exp) <= 3.0 && (exp - real'(v)) <= 3.0, "R4 count 4/6 ratio", v, longint'(exp));
    keep = v;
    wr(A_CTRL, 32'd1000);
    repeat (5) @(negedge ref_clk);
    rd(A_MON, v, vs); chk(v == keep, "R9 monitor held after disable", v, keep);

    measure(500, 10.0, 1, v, vs);
    exp = 500.0 * 4.0 / 10.0;
    chk((real'(v) - exp) <= 3.0 && (exp - real'(v)) <= 3.0, "R4 count 4/10 ratio", v, longint'(exp));

    // R6 clearing the free-run enable drops valid; re-enabling restarts
    wr(A_STAT, 32'h0);
    repeat (3) @(negedge ref_clk);
    rd(A_STAT, v, vs); chk(v[0] == 1'b0, "R6 valid cleared by free-run enable", v[0], 0);
    wr(A_STAT, 32'h0000_0100);
    repeat (ARM + 500 + SET + 4) @(negedge ref_clk);
    rd(A_STAT, v, vs); chk(v[0] == 1'b1, "R6 restart valid", v[0], 1);
    wr(A_CTRL, 32'd500);

    measure(64, 3.0, 1, v, vs);
    exp = 64.0 * 4.0 / 3.0;
    chk((real'(v) - exp) <= 3.0 && (exp - real'(v)) <= 3.0, "R4 count 4/3 ratio", v, longint'(exp));
    wr(A_CTRL, 32'd64);

    // R3 zero window counts as one cycle
    measure(0, 5.0, 1, v, vs);
    chk(v <= 32'd3, "R3 R4 zero window count", v, 1);
    wr(A_CTRL, 32'd0);

    // R5 stopped measured clock
    measure(200, 5.0, 0, v, vs);
    chk(v == 32'h0, "R5 stopped clock reads zero", v, 0);
    chk(vs == 32'h0, "R5 stopped clock narrow", vs, 0);
    wr(A_CTRL, 32'd200);

    // R8 saturation on the narrow instance
    measure(600, 3.0, 1, v, vs);
    exp = 600.0 * 4.0 / 3.0;
    chk((real'(v) - exp) <= 3.0 && (exp - real'(v)) <= 3.0, "R4 count wide", v, longint'(exp));
    chk(vs == 32'd255, "R8 narrow count saturates", vs, 255);
    wr(A_CTRL, 32'd600);
    rd(A_MON, v, vs); chk(vs == 32'd255, "R9 saturated result held", vs, 255);

    repeat (4) @(negedge ref_clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule